// File: doc/BRIEF.md
# Sequential Binary to BCD Converter

This block turns an unsigned binary operand into packed decimal digits, one bit per clock cycle, with the shift-and-add-3 method. A single register pairs the decimal digit field with the remaining binary bits. On every working cycle, each decimal digit of 5 or more first gains 3. The whole register then moves left by one place, so the top binary bit enters the units digit. After as many shifts as the operand has bits, the digit field holds the decimal value.

The interface is a two-signal handshake. A pulse on `start` while the block is not converting captures `bin_in` and begins a conversion. `ready` rises when the last shift is done and holds, with the digits frozen, until the next accepted `start`. With the default 10-bit operand and four digits, the result sits at `bcd_out[15:12]` (thousands), `[11:8]` (hundreds), `[7:4]` (tens) and `[3:0]` (units).

Top module: `bcd_shift_add3`

## Requirements
- R1: After reset, `ready` is 0 and `bcd_out` is all zeros.
- R2: A `start` sampled high while idle, or while `ready` is high, captures `bin_in` and makes `ready` low on the next cycle.
- R3: `ready` goes high exactly WIDTH (10) clock cycles after the edge that accepted `start`.
- R4: When `ready` is high, `bcd_out` holds the decimal value of the captured operand, with the thousands digit in bits [15:12] and the units digit in bits [3:0], for every operand from 0 to 1023.
- R5: The thousands digit never exceeds 1 while `ready` is high.
- R6: Every 4-bit digit field of `bcd_out` stays within 0 to 9 on every cycle, including the cycles of a conversion.
- R7: A `start` that arrives during a conversion is ignored. The result and the timing of `ready` are those of the first operand.
- R8: While `ready` is high and `start` is low, `ready` stays high and `bcd_out` does not change.
- R9: `ready` stays low during the cycles of a conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to capture `bin_in` and convert it |
| bin_in | input | 10 | Unsigned binary operand |
| ready | output | 1 | Conversion finished, digits valid |
| bcd_out | output | 16 | Four decimal digits, thousands in the top nibble |

## Verification
The per-digit add-3 correction and the left shift always happen in the same cycle, because the corrected digits are what gets shifted. Any error in their order shows up as a wrong digit. Every operand from 0 to 1023 is therefore converted and compared against a division-based decimal reference. A second coincidence comes from a `start` that lands in the middle of a conversion, while the shift sequence is still running. The bench raises `start` with a different operand mid-run and requires both the ready timing and the digits of the first operand.

// File: rtl/bcd_shift_add3.sv
module bcd_shift_add3 #(
  parameter int WIDTH  = 10,
  parameter int DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [WIDTH-1:0]      bin_in,
  output logic                  ready,
  output logic [4*DIGITS-1:0]   bcd_out
);

  localparam int BW = 4 * DIGITS;
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_t;

  state_t           state;
  logic [BW-1:0]    bcd_q, bcd_fix, bcd_nx;
  logic [WIDTH-1:0] bin_q, bin_nx;
  logic [CW-1:0]    cnt;
  logic             accept;

  genvar g;
  generate
    for (g = 0; g < DIGITS; g++) begin : g_digit
      logic [3:0] d;
      assign d = bcd_q[4*g +: 4];
      assign bcd_fix[4*g +: 4] = (d >= 4'd5) ? d + 4'd3 : d;

      p_digit_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_out[4*g +: 4] <= 4'd9);
    end
  endgenerate

  assign {bcd_nx, bin_nx} = {bcd_fix[BW-2:0], bin_q, 1'b0};
  assign accept  = start && (state != S_RUN);
  assign ready   = (state == S_DONE);
  assign bcd_out = bcd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      bcd_q <= '0;
      bin_q <= '0;
      cnt   <= '0;
    end else if (accept) begin
      state <= S_RUN;
      bcd_q <= '0;
      bin_q <= bin_in;
      cnt   <= '0;
    end else if (state == S_RUN) begin
      bcd_q <= bcd_nx;
      bin_q <= bin_nx;
      cnt   <= cnt + 1'b1;
      if (cnt == LAST) state <= S_DONE;
    end
  end

  p_start_clears_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state != S_RUN) |=> !ready);

  p_last_shift_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && cnt == LAST) |=> ready);

  p_thousands_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (bcd_out[BW-1 -: 4] <= 4'd1));

  p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && start && cnt != LAST) |=> (state == S_RUN && cnt == $past(cnt) + 1'b1));

  p_ready_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> (ready && $stable(bcd_out)));

  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN) |-> !ready);

endmodule

// File: tb/bcd_shift_add3_bench.sv
module bcd_shift_add3_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;
  localparam int NV = 10;
  localparam logic [9:0]  VIN [NV] = '{10'd0, 10'd1, 10'd5, 10'd9, 10'd10, 10'd99,
                                       10'd255, 10'd512, 10'd999, 10'd1023};
  localparam logic [15:0] VEXP[NV] = '{16'h0000, 16'h0001, 16'h0005, 16'h0009, 16'h0010,
                                       16'h0099, 16'h0255, 16'h0512, 16'h0999, 16'h1023};

  logic clk = 0, rst_n = 0, start = 0;
  logic [W-1:0] bin_in = '0;
  logic ready;
  logic [15:0] bcd_out;
  int checks = 0, fails = 0;
  bit done = 0;

  bcd_shift_add3 u_bcd_shift_add3 (.clk(clk), .rst_n(rst_n), .start(start),
    .bin_in(bin_in), .ready(ready), .bcd_out(bcd_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] ref_bcd(input int v);
    return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic convert(input int v, input bit verbose);
    @(negedge clk); bin_in = W'(v); start = 1;
    @(negedge clk); start = 0;
    if (verbose) check("R2 ready low after start", 32'(ready), 32'd0);
    repeat (W-1) @(negedge clk);
    if (verbose) check("R9 ready low before last shift", 32'(ready), 32'd0);
    @(negedge clk);
    check("R3 ready after 10 cycles", 32'(ready), 32'd1);
    check("R4/R5 digits", 32'(bcd_out), 32'(ref_bcd(v)));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready at reset", 32'(ready), 32'd0);
    check("R1 digits at reset", 32'(bcd_out), 32'd0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      convert(int'(VIN[i]), 1'b1);
      check("R4 table vector", 32'(bcd_out), 32'(VEXP[i]));
    end

    // R8: result holds while start is low
    repeat (5) @(negedge clk);
    check("R8 ready holds", 32'(ready), 32'd1);
    check("R8 digits hold", 32'(bcd_out), 32'h1023);

    // R7: start during conversion is ignored
    @(negedge clk); bin_in = 10'd678; start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    bin_in = 10'd321; start = 1;
    @(negedge clk); start = 0;
    repeat (W-5) @(negedge clk);
    check("R7 ready low mid run", 32'(ready), 32'd0);
    @(negedge clk);
    check("R7 ready timing kept", 32'(ready), 32'd1);
    check("R7 first operand result", 32'(bcd_out), 32'h0678);

    // R4 exhaustive sweep
    for (int v = 0; v < 1024; v++) convert(v, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule